// File: doc/BRIEF.md
# Static memory strobe sequencer

This block runs one access at a time to an asynchronous static memory (SRAM, NOR flash or ROM). A requester presents an address, write data, byte enables and a read/write flag with a valid bit. The block accepts the request only while it is idle. It then drives chip select and address, and places the output-enable or write-enable pulse inside the chip-select window. Each edge of that pulse is set by its own 5-bit wait field and is counted in clock cycles from the cycle in which chip select falls. At the end of the access it pulses a done flag and, for a read, presents the data it captured.

A lane-mode bit selects how the per-byte lane selects behave. With the bit at 0 they act as write strobes: they pulse with write enable on writes and stay high on reads. With the bit at 1 they act as static byte enables: they follow the byte enables for the whole chip-select window on both reads and writes. The request fields and the configuration are latched when a request is accepted, so a later change to them has no effect on the running access.

The state machine has four states: IDLE (no access, ready), SETUP (chip select low, strobe not yet active), STROBE (the output-enable or write-enable pulse is active) and HOLD (the strobe is released, chip select is still low, done is high). The transitions are:
- accept: IDLE to SETUP, or IDLE straight to STROBE when the strobe starts at cycle 0.
- lead-out: SETUP to STROBE.
- trail-out: STROBE to HOLD.
- release: HOLD to IDLE.

Top module: `smem_strobe_seq`

## Requirements
- R1: While chip select `mem_cs_n` is high, `mem_oe_n`, `mem_we_n` and every bit of `mem_bls_n` are high, `mem_wdata_oe` is 0, `rsp_done` is 0 and `req_ready` is 1. This holds from reset.
- R2: On a read with effective lead E, `mem_oe_n` is low exactly in cycles E to WAITRD, counted from 0 at the first cycle with `mem_cs_n` low. That is WAITRD−E+1 cycles. `mem_we_n` stays high for the whole read.
- R3: On a write with effective lead E, `mem_we_n` is low exactly in cycles E+1 to WAITWR+1. That is WAITWR−E+1 cycles. `mem_oe_n` stays high for the whole write.
- R4: The effective read lead is min(WAITOEN, WAITRD) and the effective write lead is min(WAITWEN, WAITWR). A lead field larger than its trail field therefore acts as equal to the trail field.
- R5: With lane mode 0, on a write `mem_bls_n[i]` is low exactly in the cycles where `mem_we_n` is low and only when byte enable bit i is 1. On a read all lane selects stay high.
- R6: With lane mode 1, `mem_bls_n` equals the inverted byte enables in every cycle with `mem_cs_n` low, on reads and writes alike.
- R7: Chip select stays low for WAITRD+2 cycles on a read and WAITWR+3 cycles on a write, ending one cycle after the last strobe cycle. `mem_addr` equals the request address throughout.
- R8: During a write, `mem_wdata_oe` is 1 and `mem_wdata` equals the request data in every cycle with `mem_cs_n` low. `mem_wdata_oe` is 0 during reads and while idle.
- R9: `rsp_done` is high for exactly one cycle, the last cycle with `mem_cs_n` low. For a read, `rsp_rdata` then holds the value that `mem_rdata` had in the last cycle with `mem_oe_n` low.
- R10: A request is taken only when `req_ready` is 1. A valid request during a running access starts nothing. Changes to the request or configuration inputs after acceptance do not alter the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | High when idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, 1 = lane used |
| cfg_wait_oen | input | 5 | Read strobe lead in cycles |
| cfg_wait_rd | input | 5 | Read strobe trail index |
| cfg_wait_wen | input | 5 | Write strobe lead in cycles |
| cfg_wait_wr | input | 5 | Write strobe trail index |
| cfg_lane_mode | input | 1 | 0 = lanes strobe on writes, 1 = static byte enables |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | DW/8 | Lane selects, active low |
| mem_wdata | output | DW | Write data toward the pad |
| mem_wdata_oe | output | 1 | Pad driver enable for write data |
| mem_rdata | input | DW | Read data from memory |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |

## Verification
The done pulse of one access and a pending new request fall in the same cycle. During HOLD, `rsp_done` is high while `req_valid` of the next request is already asserted. The bench provokes this by issuing requests back to back, so each new request waits through the tail of the previous access. A separate burst of requests is also asserted in the middle of an access and dropped before that access ends. The monitor judges the outcome cycle by cycle. Every access must show exactly the expected chip-select length followed by at least one idle cycle. The request presented during HOLD must start only after that idle cycle. The mid-access burst must start no access at all, which the bench checks through a final count of accesses against requests issued.

// File: rtl/smem_seq_pkg.sv
package smem_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/smem_wait_clamp.sv
// Limits a lead field to its trail field so that a pulse width never goes negative.
module smem_wait_clamp #(
    parameter int W = 5
) (
    input  logic [W-1:0] lead_i,
    input  logic [W-1:0] trail_i,
    output logic [W-1:0] lead_o
);
    assign lead_o = (lead_i > trail_i) ? trail_i : lead_i;
endmodule

// File: rtl/smem_phase_timer.sv
// Cycle index within an access: cleared on accept, advanced while running.
module smem_phase_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_o <= '0;
        else if (clear_i) cnt_o <= '0;
        else if (run_i)   cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/smem_strobe_seq.sv
module smem_strobe_seq
    import smem_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int WW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW/8-1:0]  req_be,
    input  logic [WW-1:0]    cfg_wait_oen,
    input  logic [WW-1:0]    cfg_wait_rd,
    input  logic [WW-1:0]    cfg_wait_wen,
    input  logic [WW-1:0]    cfg_wait_wr,
    input  logic             cfg_lane_mode,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_cs_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [DW/8-1:0]  mem_bls_n,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_wdata_oe,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_done
);
    localparam int NB = DW / 8;
    localparam int CW = WW + 1;

    seq_state_t state, state_nx;

    logic [WW-1:0] lead_raw  [2];
    logic [WW-1:0] trail_raw [2];
    logic [WW-1:0] lead_cl   [2];

    assign lead_raw[0]  = cfg_wait_oen;
    assign trail_raw[0] = cfg_wait_rd;
    assign lead_raw[1]  = cfg_wait_wen;
    assign trail_raw[1] = cfg_wait_wr;

    for (genvar g = 0; g < 2; g++) begin : g_clamp
        smem_wait_clamp #(.W(WW)) u_clamp (
            .lead_i  (lead_raw[g]),
            .trail_i (trail_raw[g]),
            .lead_o  (lead_cl[g])
        );
    end

    logic [CW-1:0] sel_start, sel_end;
    logic [CW-1:0] lat_start, lat_end;
    logic [CW-1:0] cnt;
    logic          lat_wr, lat_mode;
    logic [NB-1:0] lat_be;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          accept, last_strobe;

    // Write pulses start one cycle later than the clamped lead and end one later than the trail.
    assign sel_start = req_write ? (CW'(lead_cl[1]) + CW'(1)) : CW'(lead_cl[0]);
    assign sel_end   = req_write ? (CW'(cfg_wait_wr) + CW'(1)) : CW'(cfg_wait_rd);

    assign accept      = (state == ST_IDLE) && req_valid;
    assign last_strobe = (state == ST_STROBE) && (cnt == lat_end);

    smem_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .run_i   ((state == ST_SETUP) || (state == ST_STROBE)),
        .cnt_o   (cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: accept, lead-out, trail-out, release
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = (sel_start == '0) ? ST_STROBE : ST_SETUP;
            ST_SETUP:  if ((cnt + 1'b1) == lat_start) state_nx = ST_STROBE;
            ST_STROBE: if (cnt == lat_end) state_nx = ST_HOLD;
            ST_HOLD:   state_nx = ST_IDLE;
        endcase
    end

    // Request latch and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_wr    <= 1'b0;
            lat_mode  <= 1'b0;
            lat_start <= '0;
            lat_end   <= '0;
            lat_be    <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                lat_wr    <= req_write;
                lat_mode  <= cfg_lane_mode;
                lat_start <= sel_start;
                lat_end   <= sel_end;
                lat_be    <= req_be;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            if (last_strobe && !lat_wr) rsp_rdata <= mem_rdata;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready    = 1'b0;
        mem_cs_n     = 1'b1;
        mem_oe_n     = 1'b1;
        mem_we_n     = 1'b1;
        mem_bls_n    = '1;
        mem_wdata_oe = 1'b0;
        rsp_done     = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_SETUP, ST_HOLD: begin
                mem_cs_n     = 1'b0;
                mem_wdata_oe = lat_wr;
                if (lat_mode) mem_bls_n = ~lat_be;
                rsp_done     = (state == ST_HOLD);
            end
            ST_STROBE: begin
                mem_cs_n     = 1'b0;
                mem_wdata_oe = lat_wr;
                mem_oe_n     = lat_wr;
                mem_we_n     = !lat_wr;
                if (lat_mode || lat_wr) mem_bls_n = ~lat_be;
            end
        endcase
    end

    assign mem_addr  = lat_addr;
    assign mem_wdata = lat_wdata;
endmodule

// File: rtl/smem_strobe_seq_chk.sv
module smem_strobe_seq_chk #(
    parameter int AW = 16,
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [NB-1:0] mem_bls_n,
    input logic          mem_wdata_oe,
    input logic          rsp_done
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_oe_n && mem_we_n && (&mem_bls_n) && !mem_wdata_oe && !rsp_done));

    // R2 and R3: read and write strobes never overlap
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> mem_cs_n);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    p_no_drive_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_wdata_oe);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !mem_cs_n);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);
endmodule

bind smem_strobe_seq smem_strobe_seq_chk #(.AW(AW), .NB(DW/8)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_addr     (mem_addr),
    .mem_cs_n     (mem_cs_n),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_bls_n    (mem_bls_n),
    .mem_wdata_oe (mem_wdata_oe),
    .rsp_done     (rsp_done)
);

// File: tb/smem_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module smem_strobe_seq_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0, cfg_lane_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] req_be = '0;
    logic [4:0]    cfg_wait_oen = '0, cfg_wait_rd = '0, cfg_wait_wen = '0, cfg_wait_wr = '0;
    logic          req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_wdata_oe, rsp_done;
    logic [AW-1:0] mem_addr;
    logic [NB-1:0] mem_bls_n;
    logic [DW-1:0] mem_wdata, mem_rdata, rsp_rdata;

    // Memory model: returns data only while output enable is low
    assign mem_rdata = !mem_oe_n ? {mem_addr, ~mem_addr} : '0;

    smem_strobe_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .cfg_wait_oen(cfg_wait_oen), .cfg_wait_rd(cfg_wait_rd), .cfg_wait_wen(cfg_wait_wen),
        .cfg_wait_wr(cfg_wait_wr), .cfg_lane_mode(cfg_lane_mode), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bls_n(mem_bls_n),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
    );

    typedef struct {
        bit            wr;
        bit            mode;
        int            start;
        int            len;
        int            total;
        logic [NB-1:0] be;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0, issued = 0, seen = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: push the expectation, then present the request until it is taken
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [NB-1:0] be, input int oen, input int rd,
                         input int wen, input int wrw, input bit mode, input bit scramble);
        exp_t e;
        int lead;
        e.wr = wr; e.mode = mode; e.be = be; e.addr = a; e.wdata = d;
        if (!wr) begin
            lead = (oen > rd) ? rd : oen;
            e.start = lead; e.len = rd - lead + 1; e.total = rd + 2;
        end else begin
            lead = (wen > wrw) ? wrw : wen;
            e.start = lead + 1; e.len = wrw - lead + 1; e.total = wrw + 3;
        end
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        cfg_wait_oen = 5'(oen); cfg_wait_rd = 5'(rd);
        cfg_wait_wen = 5'(wen); cfg_wait_wr = 5'(wrw); cfg_lane_mode = mode;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        q.push_back(e);
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin   // R10: later input changes must not alter the access
            req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_be = ~be;
            cfg_wait_oen = 5'd31; cfg_wait_rd = 5'd1; cfg_wait_wen = 5'd0;
            cfg_wait_wr = 5'd31; cfg_lane_mode = ~mode;
        end
    endtask

    // Monitor: compares every cycle of an access against the queue head
    bit   active = 1'b0;
    int   t = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n) begin
                if (!active) begin
                    active = 1'b1;
                    t = 0;
                    if (q.size() == 0) begin
                        chk(1'b0, "R10 unexpected access", 64'd1, 64'd0);
                        cur.wr = 0; cur.mode = 0; cur.start = 0; cur.len = 0; cur.total = 0;
                        cur.be = '0; cur.addr = '0; cur.wdata = '0;
                    end else cur = q[0];
                end else t++;
                begin
                    bit            win;
                    logic [NB-1:0] lanes;
                    win = (t >= cur.start) && (t < cur.start + cur.len);
                    chk(mem_oe_n == !(win && !cur.wr), cur.wr ? "R3 oe high on write" : "R2 read strobe",
                        64'(mem_oe_n), 64'(!(win && !cur.wr)));
                    chk(mem_we_n == !(win && cur.wr), cur.wr ? "R3 write strobe" : "R2 we high on read",
                        64'(mem_we_n), 64'(!(win && cur.wr)));
                    if (cur.mode) lanes = ~cur.be;
                    else          lanes = (cur.wr && win) ? ~cur.be : '1;
                    chk(mem_bls_n == lanes, cur.mode ? "R6 static lanes" : "R5 strobe lanes",
                        64'(mem_bls_n), 64'(lanes));
                    chk(mem_addr == cur.addr, "R7 address held", 64'(mem_addr), 64'(cur.addr));
                    chk(mem_wdata_oe == cur.wr, "R8 data drive", 64'(mem_wdata_oe), 64'(cur.wr));
                    if (cur.wr) chk(mem_wdata == cur.wdata, "R8 write data", 64'(mem_wdata), 64'(cur.wdata));
                    chk(rsp_done == (t == cur.total - 1), "R9 done pulse", 64'(rsp_done), 64'(t == cur.total - 1));
                    if (rsp_done && !cur.wr)
                        chk(rsp_rdata == {cur.addr, ~cur.addr}, "R9 read data",
                            64'(rsp_rdata), 64'({cur.addr, ~cur.addr}));
                end
            end else begin
                if (active) begin
                    chk(t + 1 == cur.total, "R7 chip select length", 64'(t + 1), 64'(cur.total));
                    if (q.size() != 0) void'(q.pop_front());
                    seen++;
                    active = 1'b0;
                end
                chk(mem_oe_n && mem_we_n && (&mem_bls_n) && !mem_wdata_oe && !rsp_done && req_ready,
                    "R1 idle outputs", {58'd0, mem_oe_n, mem_we_n, &mem_bls_n, mem_wdata_oe, rsp_done, req_ready},
                    64'b111001);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && (&mem_bls_n) && !rsp_done && !mem_wdata_oe,
            "R1 reset state", 64'(mem_cs_n), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        issue(0, 16'h1234, 32'h0, 4'b1111, 2, 4, 0, 0, 0, 0);         // R2 R5
        issue(0, 16'h0001, 32'h0, 4'b1111, 0, 0, 0, 0, 0, 0);         // R2 minimum
        issue(1, 16'h2222, 32'hCAFE_0001, 4'b0101, 0, 0, 1, 3, 0, 0); // R3 R5 R8
        issue(1, 16'h3333, 32'h1357_9BDF, 4'b1111, 0, 0, 0, 0, 0, 0); // R3 minimum
        issue(0, 16'h4444, 32'h0, 4'b0011, 7, 3, 0, 0, 1, 1);         // R4 R6 R10
        issue(1, 16'h5555, 32'hA5A5_5A5A, 4'b1000, 0, 0, 9, 2, 1, 1); // R4 R6 R10
        issue(0, 16'hFFFF, 32'h0, 4'b1111, 31, 31, 0, 0, 0, 0);       // R2 maximum
        issue(1, 16'h0F0F, 32'hDEAD_BEEF, 4'b0110, 0, 0, 31, 31, 1, 0); // R3 maximum

        // R10: requests raised during a busy access start nothing
        issue(0, 16'h6666, 32'h0, 4'b1111, 1, 6, 0, 0, 0, 0);
        @(negedge clk);
        req_write = 1'b1; req_addr = 16'h7777; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk(seen == issued, "R10 busy request ignored", 64'(seen), 64'(issued));

        // Back to back: each request waits through the previous done cycle
        issue(1, 16'h8888, 32'h0BAD_F00D, 4'b1111, 0, 0, 2, 2, 0, 0);
        issue(0, 16'h9999, 32'h0, 4'b1111, 0, 1, 0, 0, 1, 0);
        issue(1, 16'hAAAA, 32'h1111_2222, 4'b0001, 0, 0, 0, 1, 1, 0);
        repeat (40) @(negedge clk);

        chk(seen == issued, "R10 access count", 64'(seen), 64'(issued));
        chk(q.size() == 0, "R9 every access completed", 64'(q.size()), 64'd0);
        finish_run();
    end
endmodule